// File: doc/BRIEF.md
# Multi-Operand Computation Unit Sequencer

This block sequences one computation unit of a scoreboard-scheduled core. An operation may consume up to three source operands and produce up to two results. When the unit is idle and an operation is issued, the unit becomes busy. It then raises a read request for each operand the operation actually uses. Each request is granted on its own by a per-operand go-read strobe. Grants may come one at a time, in any mix, or all in one cycle. A unit that wins only one register-file read port in a cycle therefore still makes progress: it captures that one operand and waits for the rest.

The write phase starts only after every operand has been captured. The unit then raises one write request per result used, and each is granted by its own go-write strobe, in any order. When the last write is granted the unit goes idle and can take the next issue. Each accepted go-read is answered by a one-cycle read-release pulse, which confirms the grant to the scheduler. A small stand-in datapath forms the results from the captured operands.

Top module: `mcu_ctrl`

## Requirements
- R1: After reset, busy_o, rd_req_o, wr_req_o and rd_rel_o are all zero.
- R2: An issue_i seen while idle sets busy_o from the next cycle. From that cycle, rd_req_o[i] is high for each set bit of rd_use_i. Bit i selects operand slot i, which is bits [i*DW +: DW] of opnd_i.
- R3: A go_rd_i[i] that meets a raised rd_req_o[i] captures operand slot i at that clock edge and clears rd_req_o[i] from the next cycle. Other slots are unaffected, whatever the order or combination of grants, including all in one cycle.
- R4: rd_rel_o[i] is high for exactly the one cycle after a go_rd_i[i] was accepted, and is low at all other times.
- R5: wr_req_o is zero while any read request is outstanding. In the cycle after the last read is accepted, or the cycle after issue if no operand is used, wr_req_o[j] rises for each set bit of wr_use_i.
- R6: A go_wr_i[j] that meets a raised wr_req_o[j] clears that request from the next cycle, independently of the other result slot.
- R7: busy_o falls in the cycle after the last outstanding write is accepted. If no result is used, it falls in the cycle after the reads complete. While idle, no request is raised.
- R8: Slots whose use bit was clear at issue are never requested during that operation.
- R9: A go-read or go-write strobe for a slot with no raised request has no effect. No data is captured, no release is pulsed, and no request changes.
- R10: issue_i while busy_o is high has no effect on requests, captured data or busy_o.
- R11: While write requests are raised, result slot 0 (result_o[DW-1:0]) holds the sum modulo 2^DW of the captured operands. Result slot 1 holds their bitwise XOR. Operands not used by the operation count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue a new operation (taken only when idle) |
| rd_use_i | input | N_RD | Operand slots used by the issued operation |
| wr_use_i | input | N_WR | Result slots used by the issued operation |
| go_rd_i | input | N_RD | Per-operand read grant |
| go_wr_i | input | N_WR | Per-result write grant |
| opnd_i | input | N_RD*DW | Operand data from the register read ports, slot i at [i*DW +: DW] |
| busy_o | output | 1 | Unit holds an operation |
| rd_req_o | output | N_RD | Per-operand read request |
| rd_rel_o | output | N_RD | Per-operand read-release pulse |
| wr_req_o | output | N_WR | Per-result write request |
| result_o | output | N_WR*DW | Result data, slot j at [j*DW +: DW] |

## Verification
Two events can fall in the same cycle: the grant that completes the read phase and a grant for another slot. Likewise, the final write grant can coincide with a new issue attempt. Directed cases grant all three reads in one edge and both writes in one edge. They also send issue and stray go-write strobes during the read phase. Random traffic then mixes grants freely, so partial and complete grants often coincide. A cycle-level reference model in the bench judges every cycle. It compares the requests, releases, busy state and results against the values that model predicts.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int unsigned MCU_N_RD = 3;
  localparam int unsigned MCU_N_WR = 2;
  localparam int unsigned MCU_DW   = 16;
endpackage

// File: rtl/mcu_rd_slot.sv
module mcu_rd_slot #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          used_i,
  input  logic          busy_i,
  input  logic          go_i,
  input  logic [DW-1:0] d_i,
  output logic          req_o,
  output logic          done_o,
  output logic          rel_o,
  output logic [DW-1:0] q_o
);
  logic done_q, rel_q, acc;
  logic [DW-1:0] q_q;

  assign req_o = busy_i & ~done_q;
  assign acc   = go_i & req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      rel_q  <= 1'b0;
      q_q    <= '0;
    end else begin
      rel_q <= acc;
      if (start_i) begin
        done_q <= ~used_i;
        q_q    <= '0;
      end else if (acc) begin
        done_q <= 1'b1;
        q_q    <= d_i;
      end
    end
  end

  assign done_o = done_q;
  assign rel_o  = rel_q;
  assign q_o    = q_q;
endmodule

// File: rtl/mcu_wr_slot.sv
module mcu_wr_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic used_i,
  input  logic busy_i,
  input  logic rd_all_i,
  input  logic go_i,
  output logic req_o,
  output logic done_nxt_o
);
  logic done_q;

  assign req_o      = busy_i & rd_all_i & ~done_q;
  assign done_nxt_o = done_q | (go_i & req_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_q <= 1'b1;
    else if (start_i) done_q <= ~used_i;
    else              done_q <= done_nxt_o;
  end
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu #(
  parameter int unsigned N_RD = 3,
  parameter int unsigned N_WR = 2,
  parameter int unsigned DW   = 16
) (
  input  logic [N_RD*DW-1:0] op_i,
  output logic [N_WR*DW-1:0] res_o
);
  logic [DW-1:0] sum, xr;

  always_comb begin
    sum = '0;
    xr  = '0;
    for (int i = 0; i < N_RD; i++) begin
      sum = sum + op_i[i*DW +: DW];
      xr  = xr ^ op_i[i*DW +: DW];
    end
  end

  // slot 0 sum, slot 1 xor, further slots repeat the pattern
  for (genvar j = 0; j < N_WR; j++) begin : g_res
    if (j % 2 == 0) begin : g_sum
      assign res_o[j*DW +: DW] = sum;
    end else begin : g_xor
      assign res_o[j*DW +: DW] = xr;
    end
  end
endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
  import mcu_pkg::*;
#(
  parameter int unsigned N_RD = MCU_N_RD,
  parameter int unsigned N_WR = MCU_N_WR,
  parameter int unsigned DW   = MCU_DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic [N_RD-1:0]    rd_use_i,
  input  logic [N_WR-1:0]    wr_use_i,
  input  logic [N_RD-1:0]    go_rd_i,
  input  logic [N_WR-1:0]    go_wr_i,
  input  logic [N_RD*DW-1:0] opnd_i,
  output logic               busy_o,
  output logic [N_RD-1:0]    rd_req_o,
  output logic [N_RD-1:0]    rd_rel_o,
  output logic [N_WR-1:0]    wr_req_o,
  output logic [N_WR*DW-1:0] result_o
);
  localparam int unsigned OPW = N_RD * DW;

  logic            busy_q, start, rd_all;
  logic [N_RD-1:0] rd_done;
  logic [N_WR-1:0] wr_done_nxt;
  logic [OPW-1:0]  op_q;

  assign start  = issue_i & ~busy_q;
  assign rd_all = &rd_done;

  for (genvar i = 0; i < N_RD; i++) begin : g_rd
    mcu_rd_slot #(.DW(DW)) u_rd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start),
      .used_i (rd_use_i[i]),
      .busy_i (busy_q),
      .go_i   (go_rd_i[i]),
      .d_i    (opnd_i[i*DW +: DW]),
      .req_o  (rd_req_o[i]),
      .done_o (rd_done[i]),
      .rel_o  (rd_rel_o[i]),
      .q_o    (op_q[i*DW +: DW])
    );
  end

  for (genvar j = 0; j < N_WR; j++) begin : g_wr
    mcu_wr_slot u_wr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .used_i    (wr_use_i[j]),
      .busy_i    (busy_q),
      .rd_all_i  (rd_all),
      .go_i      (go_wr_i[j]),
      .req_o     (wr_req_o[j]),
      .done_nxt_o(wr_done_nxt[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          busy_q <= 1'b0;
    else if (start)                       busy_q <= 1'b1;
    else if (busy_q & rd_all & (&wr_done_nxt)) busy_q <= 1'b0;
  end

  mcu_alu #(.N_RD(N_RD), .N_WR(N_WR), .DW(DW)) u_alu (
    .op_i (op_q),
    .res_o(result_o)
  );

  assign busy_o = busy_q;
endmodule

// File: rtl/mcu_ctrl_chk.sv
module mcu_ctrl_chk #(
  parameter int unsigned N_RD = 3,
  parameter int unsigned N_WR = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_i,
  input logic [N_RD-1:0] go_rd_i,
  input logic [N_WR-1:0] go_wr_i,
  input logic            busy_o,
  input logic [N_RD-1:0] rd_req_o,
  input logic [N_RD-1:0] rd_rel_o,
  input logic [N_WR-1:0] wr_req_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_req_o == '0 && wr_req_o == '0)); // R7
  AST_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && issue_i) |=> busy_o); // R2
  AST_RD_BEFORE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o != '0) |-> (rd_req_o == '0)); // R5
  AST_RD_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    ((go_rd_i & rd_req_o) != '0) |=> ((rd_req_o & $past(go_rd_i & rd_req_o)) == '0)); // R3
  AST_REL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    seen |=> (rd_rel_o == $past(go_rd_i & rd_req_o))); // R4
  AST_WR_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    ((go_wr_i & wr_req_o) != '0) |=> ((wr_req_o & $past(go_wr_i & wr_req_o)) == '0)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    (busy_o && wr_req_o == '0 && rd_req_o != '0) |=> busy_o); // R10
endmodule

bind mcu_ctrl mcu_ctrl_chk #(.N_RD(N_RD), .N_WR(N_WR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .issue_i (issue_i),
  .go_rd_i (go_rd_i),
  .go_wr_i (go_wr_i),
  .busy_o  (busy_o),
  .rd_req_o(rd_req_o),
  .rd_rel_o(rd_rel_o),
  .wr_req_o(wr_req_o)
);

// File: tb/mcu_ctrl_test.sv
`timescale 1ns/1ps
module mcu_ctrl_test;
  localparam int NR = 3;
  localparam int NW = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue;
  logic [NR-1:0] rd_use, go_rd, rd_req, rd_rel;
  logic [NW-1:0] wr_use, go_wr, wr_req;
  logic [NR*DW-1:0] opnd;
  logic [NW*DW-1:0] result;
  logic busy;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit            m_busy;
  bit [NR-1:0]   m_rd_done, m_rel;
  bit [NW-1:0]   m_wr_done;
  bit [DW-1:0]   m_op [NR];

  always #2 clk = ~clk;

  mcu_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue), .rd_use_i(rd_use),
    .wr_use_i(wr_use), .go_rd_i(go_rd), .go_wr_i(go_wr), .opnd_i(opnd),
    .busy_o(busy), .rd_req_o(rd_req), .rd_rel_o(rd_rel), .wr_req_o(wr_req),
    .result_o(result)
  );

  function automatic bit [NR-1:0] e_rd_req();
    return m_busy ? ~m_rd_done : '0;
  endfunction

  function automatic bit [NW-1:0] e_wr_req();
    return (m_busy && (&m_rd_done)) ? ~m_wr_done : '0;
  endfunction

  function automatic bit [NW*DW-1:0] e_result();
    bit [DW-1:0] s = '0, x = '0;
    bit [NW*DW-1:0] r;
    for (int i = 0; i < NR; i++) begin
      s = s + m_op[i];
      x = x ^ m_op[i];
    end
    for (int j = 0; j < NW; j++) r[j*DW +: DW] = (j % 2 == 0) ? s : x;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R7 busy", 64'(busy), 64'(m_busy));
    chk("R3/R8/R9 rd_req", 64'(rd_req), 64'(e_rd_req()));
    chk("R4 rd_rel", 64'(rd_rel), 64'(m_rel));
    chk("R5/R6 wr_req", 64'(wr_req), 64'(e_wr_req()));
    if (e_wr_req() != '0) chk("R11 result", 64'(result), 64'(e_result()));
  endtask

  // drive at negedge, check, then update model at posedge
  task automatic step(input bit iss, input bit [NR-1:0] ru, input bit [NW-1:0] wu,
                      input bit [NR-1:0] gr, input bit [NW-1:0] gw, input bit [NR*DW-1:0] d);
    bit [NR-1:0] acc_rd;
    bit [NW-1:0] acc_wr, nwd;
    @(negedge clk);
    issue = iss; rd_use = ru; wr_use = wu; go_rd = gr; go_wr = gw; opnd = d;
    #1 compare();
    acc_rd = gr & e_rd_req();
    acc_wr = gw & e_wr_req();
    @(posedge clk);
    if (!m_busy) begin
      m_rel = '0;
      if (iss) begin
        m_busy = 1; m_rd_done = ~ru; m_wr_done = ~wu;
        for (int i = 0; i < NR; i++) m_op[i] = '0;
      end
    end else begin
      for (int i = 0; i < NR; i++) if (acc_rd[i]) m_op[i] = d[i*DW +: DW];
      m_rel = acc_rd;
      nwd = m_wr_done | acc_wr;
      if ((&m_rd_done) && (&nwd)) m_busy = 0;
      m_rd_done = m_rd_done | acc_rd;
      m_wr_done = nwd;
    end
  endtask

  function automatic bit [NR*DW-1:0] rnd_d();
    bit [NR*DW-1:0] r;
    for (int i = 0; i < NR; i++) r[i*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5));
    issue = 0; rd_use = 0; wr_use = 0; go_rd = 0; go_wr = 0; opnd = 0;
    m_busy = 0; m_rd_done = '1; m_wr_done = '1; m_rel = '0;
    for (int i = 0; i < NR; i++) m_op[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rd_req", 64'(rd_req), 64'd0);
    chk("R1 wr_req", 64'(wr_req), 64'd0);
    chk("R1 rd_rel", 64'(rd_rel), 64'd0);
    rst_ni = 1;

    // R2 R3: all three reads in one cycle, both writes in one cycle
    step(1, 3'b111, 2'b11, 0, 0, 0);
    step(0, 0, 0, 0, 2'b11, rnd_d());          // R9 stray go-write in read phase
    step(0, 0, 0, 3'b111, 0, {16'h0003, 16'h0002, 16'hFFFF});
    step(0, 0, 0, 0, 0, 0);                    // R4 release, R11 wrap sum
    step(0, 0, 0, 0, 2'b11, 0);
    step(0, 0, 0, 0, 0, 0);                    // R7 idle again

    // R8 R9 R10: sparse use, one port per cycle, stray grants, issue while busy
    step(1, 3'b101, 2'b10, 0, 0, 0);
    step(1, 3'b010, 2'b01, 3'b010, 0, {16'h1111, 16'h2222, 16'h3333}); // R10 R9
    step(0, 0, 0, 3'b001, 0, {16'h0, 16'h0, 16'h00A0});
    step(0, 0, 0, 3'b100, 0, {16'h0B00, 16'h0, 16'h0});
    step(1, 3'b111, 2'b11, 0, 2'b01, 0);       // R9 R10
    step(0, 0, 0, 0, 2'b10, 0);
    step(0, 0, 0, 0, 0, 0);

    // R5 R7: empty operation
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 1) == 1, NR'($urandom), NW'($urandom),
           NR'($urandom), NW'($urandom), rnd_d());
    end
    step(0, 0, 0, '1, '1, 0);
    step(0, 0, 0, '1, '1, 0);
    step(0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule